// File: doc/BRIEF.md
# Three-Parallel Fast FIR Filter

This block is a fixed-coefficient FIR filter that consumes one block of three consecutive input samples per clock and returns the matching block of three filtered samples. Lane 0 carries the oldest sample of a block, and lane 2 carries the newest. Each lane of the input and each phase of the coefficient set forms its own polyphase stream.

The filter does not run nine phase-by-phase convolutions. It forms three lane sums on the data and the same three sums on the coefficients. It then runs six short convolutions, each N/3 taps long, over the three plain lanes and the three sums. Post-adders recombine the six partial results. Some terms cross the block boundary, and these are taken from the previous block's partial results. One block of delay is one accepted input block, not one clock.

Coefficients are fixed when the design is elaborated. All arithmetic is exact, and each output is the full-precision filter sum. Idle cycles with the strobe low leave the filter history untouched.

Top module: `fir3_fast`

## Requirements
- R1: After reset, `out_valid` is low and all three outputs read zero. The filter history is all zero, so the first outputs equal a convolution that assumes zero samples before the first accepted block.
- R2: For accepted block k, output lane p (p = 0, 1, 2) carries y(3k+p) = sum over i of h(i)·x(3k+p-i). Here x(3k+p) is the value on input lane p of block k, and h(i) is bits [i·CW +: CW] of `COEFS`, read as signed.
- R3: Outputs are exact two's-complement values of width OUT_W = W+CW+clog2(N), including when every input and coefficient sits at its most negative or most positive value.
- R4: `out_valid` rises exactly two clocks after each clock in which `in_valid` is high, and only then.
- R5: A cycle with `in_valid` low does not advance the filter history. Outputs after a gap equal those of the same blocks sent back to back.
- R6: A sample on lane 1 or lane 2 of block k affects output lanes 0 and 1 of block k+1, through the block-delay terms.
- R7: The same RTL is correct for any tap count N that is a multiple of 3, including N = 12 and N = 27.
- R8: While `out_valid` is low, the three outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A new input block is present on the lanes |
| x0 | input | W | Input sample 3k (oldest of block) |
| x1 | input | W | Input sample 3k+1 |
| x2 | input | W | Input sample 3k+2 (newest of block) |
| out_valid | output | 1 | Output lanes hold a new block |
| y0 | output | OUT_W | Output sample 3k |
| y1 | output | OUT_W | Output sample 3k+1 |
| y2 | output | OUT_W | Output sample 3k+2 |

## Verification
The hardest case to reach from the ports is a gap in `in_valid` that falls between a block and the block whose cross-boundary terms depend on it. If the block-delay registers advanced on idle clocks, the error would show only in lanes 0 and 1 of the next accepted block. The stimulus therefore mixes random strobe gaps with directed impulses on lanes 1 and 2. It also runs a stretch of all-extreme samples against coefficients that include both end values, which drives every partial sum to its largest magnitude. Two instances, one with 12 taps and one with 27, share the stimulus, and every output is compared with a serial direct-form model.

// File: rtl/fir3_pkg.sv
package fir3_pkg;
    localparam int LANES = 3;
    localparam int NSUB  = 6;

    // Sub-filter slots: three plain phases and three phase sums
    typedef enum int {
        S_P0   = 0,
        S_P1   = 1,
        S_P2   = 2,
        S_P01  = 3,
        S_P12  = 4,
        S_P012 = 5
    } sub_e;
endpackage

// File: rtl/fir3_preadd.sv
module fir3_preadd
    import fir3_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int OUT_W = IN_W + 2
) (
    input  logic signed [IN_W-1:0]  a0,
    input  logic signed [IN_W-1:0]  a1,
    input  logic signed [IN_W-1:0]  a2,
    output logic signed [OUT_W-1:0] s [NSUB]
);
    logic signed [OUT_W-1:0] e0, e1, e2, s01;

    always_comb begin
        e0  = OUT_W'(a0);
        e1  = OUT_W'(a1);
        e2  = OUT_W'(a2);
        s01 = e0 + e1;
        s[S_P0]   = e0;
        s[S_P1]   = e1;
        s[S_P2]   = e2;
        s[S_P01]  = s01;
        s[S_P12]  = e1 + e2;
        // the three-lane sum reuses the lane 0+1 sum
        s[S_P012] = s01 + e2;
    end
endmodule

// File: rtl/fir3_subfilt.sv
module fir3_subfilt #(
    parameter int M     = 4,
    parameter int IW    = 10,
    parameter int CC    = 10,
    parameter int ACC_W = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [IW-1:0]    din,
    input  logic signed [CC-1:0]    coef [M],
    output logic signed [ACC_W-1:0] acc
);
    typedef struct packed {
        logic [M-1:0][IW-1:0] line;
        logic [ACC_W-1:0]     acc;
    } sf_st_t;

    sf_st_t st_d, st_q;
    logic signed [ACC_W-1:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = '0;
        if (en) begin
            for (int j = M - 1; j > 0; j--) begin
                st_d.line[j] = st_q.line[j-1];
            end
            st_d.line[0] = din;
            for (int j = 0; j < M; j++) begin
                sum = sum + ACC_W'(signed'(st_d.line[j])) * ACC_W'(coef[j]);
            end
            st_d.acc = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc = signed'(st_q.acc);
endmodule

// File: rtl/fir3_fast.sv
module fir3_fast
    import fir3_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 8,
    parameter int N  = 12,
    parameter logic [N*CW-1:0] COEFS = {N{{(CW-1){1'b0}}, 1'b1}},
    localparam int OUT_W = W + CW + $clog2(N)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [W-1:0]     x0,
    input  logic signed [W-1:0]     x1,
    input  logic signed [W-1:0]     x2,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] y0,
    output logic signed [OUT_W-1:0] y1,
    output logic signed [OUT_W-1:0] y2
);
    localparam int M     = N / LANES;
    localparam int IW    = W + 2;
    localparam int CC    = CW + 2;
    localparam int ACC_W = W + CW + 5 + $clog2(M);

    logic signed [IW-1:0]    dsum [NSUB];
    logic signed [CC-1:0]    cf   [NSUB][M];
    logic signed [ACC_W-1:0] part [NSUB];

    fir3_preadd #(.IN_W(W), .OUT_W(IW)) u_dpre (
        .a0(x0), .a1(x1), .a2(x2), .s(dsum)
    );

    for (genvar j = 0; j < M; j++) begin : g_tap
        logic signed [CC-1:0] tap_s [NSUB];
        fir3_preadd #(.IN_W(CW), .OUT_W(CC)) u_cpre (
            .a0(COEFS[(3*j)*CW +: CW]),
            .a1(COEFS[(3*j+1)*CW +: CW]),
            .a2(COEFS[(3*j+2)*CW +: CW]),
            .s (tap_s)
        );
        for (genvar s = 0; s < NSUB; s++) begin : g_cs
            assign cf[s][j] = tap_s[s];
        end
    end

    for (genvar s = 0; s < NSUB; s++) begin : g_sf
        fir3_subfilt #(.M(M), .IW(IW), .CC(CC), .ACC_W(ACC_W)) u_sf (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (in_valid),
            .din  (dsum[s]),
            .coef (cf[s]),
            .acc  (part[s])
        );
    end

    // post-adder stage with the block-delay terms
    typedef struct packed {
        logic             vld1;
        logic             ovld;
        logic [ACC_W-1:0] pw;   // previous block: A12 - A1 - A2
        logic [ACC_W-1:0] pa2;  // previous block: A2
        logic [OUT_W-1:0] y0;
        logic [OUT_W-1:0] y1;
        logic [OUT_W-1:0] y2;
    } post_st_t;

    post_st_t st_d, st_q;
    logic signed [ACC_W-1:0] t0, t1, t2;

    always_comb begin
        st_d      = st_q;
        st_d.vld1 = in_valid;
        st_d.ovld = st_q.vld1;
        t0 = '0;
        t1 = '0;
        t2 = '0;
        if (st_q.vld1) begin
            t0 = part[S_P0] + signed'(st_q.pw);
            t1 = part[S_P01] - part[S_P0] - part[S_P1] + signed'(st_q.pa2);
            t2 = part[S_P012] - part[S_P01] - part[S_P12] + part[S_P1] + part[S_P1];
            st_d.y0  = OUT_W'(t0);
            st_d.y1  = OUT_W'(t1);
            st_d.y2  = OUT_W'(t2);
            st_d.pw  = part[S_P12] - part[S_P1] - part[S_P2];
            st_d.pa2 = part[S_P2];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ovld;
    assign y0 = signed'(st_q.y0);
    assign y1 = signed'(st_q.y1);
    assign y2 = signed'(st_q.y2);
endmodule

// File: rtl/fir3_fast_chk.sv
module fir3_fast_chk #(
    parameter int W     = 8,
    parameter int CW    = 8,
    parameter int N     = 12,
    parameter int OUT_W = 20
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] y0,
    input logic signed [OUT_W-1:0] y1,
    input logic signed [OUT_W-1:0] y2
);
    localparam longint BOUND = longint'(N) * (longint'(1) << (W + CW - 2));

    function automatic logic in_range(logic signed [OUT_W-1:0] v);
        return (longint'(v) <= BOUND) && (longint'(v) >= -BOUND);
    endfunction

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(y0) && $stable(y1) && $stable(y2)));

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (in_range(y0) && in_range(y1) && in_range(y2)));
endmodule

bind fir3_fast fir3_fast_chk #(.W(W), .CW(CW), .N(N), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .y0(y0), .y1(y1), .y2(y2)
);

// File: tb/fir3_fast_bench.sv
module fir3_fast_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int CW  = 8;
    localparam int NA  = 12;
    localparam int NB  = 27;
    localparam int OWA = W + CW + $clog2(NA);
    localparam int OWB = W + CW + $clog2(NB);

    function automatic logic [NB*CW-1:0] mk_coefs(int n, int seed);
        logic [NB*CW-1:0] v;
        v = '0;
        for (int i = 0; i < n; i++) begin
            v[i*CW +: CW] = CW'(((i * 37 + seed * 11) % 256) - 128);
        end
        v[0 +: CW]       = CW'(-128);
        v[(n-1)*CW +: CW] = CW'(127);
        return v;
    endfunction

    localparam logic [NB*CW-1:0] CA_FULL = mk_coefs(NA, 3);
    localparam logic [NA*CW-1:0] CA = CA_FULL[NA*CW-1:0];
    localparam logic [NB*CW-1:0] CB = mk_coefs(NB, 7);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [W-1:0] x0 = '0, x1 = '0, x2 = '0;
    logic ova, ovb;
    logic signed [OWA-1:0] ya0, ya1, ya2;
    logic signed [OWB-1:0] yb0, yb1, yb2;

    always #(CLK_PERIOD/2) clk = ~clk;

    fir3_fast #(.W(W), .CW(CW), .N(NA), .COEFS(CA)) u_fir3_fast (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x0(x0), .x1(x1), .x2(x2),
        .out_valid(ova), .y0(ya0), .y1(ya1), .y2(ya2)
    );

    fir3_fast #(.W(W), .CW(CW), .N(NB), .COEFS(CB)) u_fir3_fast_27 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x0(x0), .x1(x1), .x2(x2),
        .out_valid(ovb), .y0(yb0), .y1(yb1), .y2(yb2)
    );

    int xs [0:4095];
    int nsent = 0;
    int rcv_a = 0, rcv_b = 0;
    int checks = 0, fails = 0;
    string tag = "R2";
    logic [1:0] vhist = 2'b00;
    longint last_a [3];
    longint last_b [3];

    function automatic longint hcoef(int which, int i);
        if (which == 0) return longint'(signed'(CA[i*CW +: CW]));
        return longint'(signed'(CB[i*CW +: CW]));
    endfunction

    function automatic longint refy(int which, int n);
        longint s = 0;
        int taps = (which == 0) ? NA : NB;
        for (int i = 0; i < taps; i++) begin
            if (n - i >= 0) s += hcoef(which, i) * longint'(xs[n-i]);
        end
        return s;
    endfunction

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) vhist <= {vhist[0], in_valid};

    always @(negedge clk) begin
        if (rst_n) begin
            check("R4 valid timing A", longint'(ova), longint'(vhist[1]));
            check("R4 valid timing B", longint'(ovb), longint'(vhist[1]));
            if (ova) begin
                check({tag, " A lane0"}, longint'(ya0), refy(0, 3*rcv_a));
                check({tag, " A lane1"}, longint'(ya1), refy(0, 3*rcv_a+1));
                check({tag, " A lane2"}, longint'(ya2), refy(0, 3*rcv_a+2));
                rcv_a++;
            end else begin
                check("R8 hold A", longint'(ya0) + 3*longint'(ya1) + 7*longint'(ya2),
                      last_a[0] + 3*last_a[1] + 7*last_a[2]);
            end
            if (ovb) begin
                check({tag, " R7 B lane0"}, longint'(yb0), refy(1, 3*rcv_b));
                check({tag, " R7 B lane1"}, longint'(yb1), refy(1, 3*rcv_b+1));
                check({tag, " R7 B lane2"}, longint'(yb2), refy(1, 3*rcv_b+2));
                rcv_b++;
            end else begin
                check("R8 hold B", longint'(yb0) + 3*longint'(yb1) + 7*longint'(yb2),
                      last_b[0] + 3*last_b[1] + 7*last_b[2]);
            end
            last_a[0] = ya0; last_a[1] = ya1; last_a[2] = ya2;
            last_b[0] = yb0; last_b[1] = yb1; last_b[2] = yb2;
        end
    end

    task automatic send(int a, int b, int c, bit v);
        @(negedge clk);
        in_valid = v;
        x0 = W'(a);
        x1 = W'(b);
        x2 = W'(c);
        if (v) begin
            xs[3*nsent]   = a;
            xs[3*nsent+1] = b;
            xs[3*nsent+2] = c;
            nsent++;
        end
    endtask

    function automatic int rs();
        return int'($urandom % 256) - 128;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        last_a = '{0, 0, 0};
        last_b = '{0, 0, 0};
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 out_valid A", longint'(ova), 0);
        check("R1 out_valid B", longint'(ovb), 0);
        check("R1 zero outputs", longint'(ya0) + longint'(yb2), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 quiet after reset", longint'(ova | ovb), 0);

        // R6: impulses on lanes 1 and 2 then zeros
        tag = "R6";
        send(0, 0, 1, 1);
        for (int i = 0; i < 10; i++) send(0, 0, 0, 1);
        send(0, 1, 0, 1);
        for (int i = 0; i < 10; i++) send(0, 0, 0, 1);

        // R2: random back to back
        tag = "R2";
        for (int i = 0; i < 120; i++) send(rs(), rs(), rs(), 1);

        // R3: extreme values
        tag = "R3";
        for (int i = 0; i < 12; i++) send(-128, -128, -128, 1);
        for (int i = 0; i < 12; i++) send(127, 127, 127, 1);
        for (int i = 0; i < 12; i++) send((i % 2) ? 127 : -128, (i % 2) ? -128 : 127, -128, 1);

        // R5: random with idle gaps, incl. gaps after lane-2 impulses
        tag = "R5";
        for (int i = 0; i < 150; i++) begin
            if ($urandom % 2 == 0) send(rs(), rs(), rs(), 0);
            send(rs(), rs(), rs(), 1);
        end
        send(0, 0, 90, 1);
        send(5, 5, 5, 0);
        send(5, 5, 5, 0);
        send(0, 0, 0, 1);
        send(0, 0, 0, 0);

        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 all blocks returned A", longint'(rcv_a), longint'(nsent));
        check("R4 all blocks returned B", longint'(rcv_b), longint'(nsent));
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule